// File: doc/BRIEF.md
# Inter-access idle gap inserter

This block sits between an external bus access sequencer and the bus pin logic. It holds off the start of each external access until enough idle cycles have passed since the previous access ended. This gives a slow device time to release the data bus before the next access drives it. The required gap is chosen separately for every pair of accesses. It depends on the direction of the earlier access and of the new one, and on whether both target the same chip-select space. It also depends on whether the earlier access was a DMA single transfer in which an external device drove the data.

The sequencer presents a request with its direction, its space index and a flag that marks an externally driven DMA single transfer. It starts the access in the cycle in which `req_valid` and `req_ready` are both high. It pulses `acc_end` during the last cycle of that access. From the end of an access the block counts idle cycles, saturating at the largest field value. A request that arrives after the required count has already passed starts without any extra delay. `busy` tells a downstream bus arbiter that a bus cycle is still in progress. This covers both the access itself and any period in which a request is being held off.

Top module: `bus_idle_gap`

## Requirements
- R1: After reset, before any access has completed, `busy` is 0 and `req_ready` is 1.
- R2: After a write, the gap before the next access of either direction is the per-space write field `cfg_gap_wr`. The field for space s is bits [3s+2:3s], and the 3-bit value gives the number of idle cycles, 0 to 7.
- R3: After a read, the gap before a write is `cfg_gap_rw_same` when both spaces match and `cfg_gap_rw_diff` when they differ. The fields are packed as in R2.
- R4: After a read, the gap before a read is `cfg_gap_rr_same` when both spaces match and `cfg_gap_rr_diff` when they differ. The fields are packed as in R2.
- R5: The per-space fields are always read for the space of the earlier access, never for the space of the new access.
- R6: When `cfg_dma_any` is 0, the DMA field `cfg_dma_gap` takes part only if the earlier access and the new access both have `req_dma_ext` set to 1.
- R7: When `cfg_dma_any` is 1, the DMA field takes part whenever the earlier access had `req_dma_ext` set to 1, whatever the new access is.
- R8: When the DMA field takes part, the gap is the larger of the DMA field and the field chosen by R2 to R4.
- R9: Idle cycles that pass with no request pending count toward the gap. A request made d cycles after an access ends waits max(gap − d, 0) cycles.
- R10: `req_ready` is 0 from the cycle after an access starts until the cycle after its `acc_end`.
- R11: `busy` is 1 during an access and in every cycle in which a request is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Sequencer wants to start an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | SPW | Chip-select space of the request |
| req_dma_ext | input | 1 | Request is a DMA single transfer with externally driven data |
| req_ready | output | 1 | Access may start this cycle |
| acc_end | input | 1 | Last cycle of the running access |
| cfg_gap_wr | input | NSPACE*FW | Per-space gap after a write |
| cfg_gap_rw_diff | input | NSPACE*FW | Per-space gap, read then write, different spaces |
| cfg_gap_rw_same | input | NSPACE*FW | Per-space gap, read then write, same space |
| cfg_gap_rr_diff | input | NSPACE*FW | Per-space gap, read then read, different spaces |
| cfg_gap_rr_same | input | NSPACE*FW | Per-space gap, read then read, same space |
| cfg_dma_gap | input | FW | Gap after an externally driven DMA single transfer |
| cfg_dma_any | input | 1 | 1 = DMA gap applies before any access |
| busy | output | 1 | Bus cycle in progress or request held off |

## Verification
The idle counter starts at zero on the clock edge that samples `acc_end`. It then advances once per edge. With the request raised right after that edge, `req_ready` therefore rises exactly after as many low samples as the gap, or after that number less the idle cycles already spent. The bench counts the low samples of `req_ready` between raising a request and seeing it high, taking each sample at the falling edge, and compares that count with a gap it derives from the field tables. `busy` and `req_ready` are combinational from registered state. For this reason the bench checks them at the falling edge of the same cycle, once during each access and once in every held-off cycle.

// File: rtl/bus_idle_gap_pkg.sv
package bus_idle_gap_pkg;

  // Direction/space category of an access pair
  typedef enum logic [2:0] {
    CAT_AFTER_WR  = 3'd0,
    CAT_RW_DIFF   = 3'd1,
    CAT_RW_SAME   = 3'd2,
    CAT_RR_DIFF   = 3'd3,
    CAT_RR_SAME   = 3'd4
  } gap_cat_e;

  function automatic gap_cat_e pick_cat(input logic prev_wr, input logic next_wr,
                                        input logic same_space);
    if (prev_wr) return CAT_AFTER_WR;
    if (next_wr) return same_space ? CAT_RW_SAME : CAT_RW_DIFF;
    return same_space ? CAT_RR_SAME : CAT_RR_DIFF;
  endfunction

  function automatic int unsigned larger(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic dma_gap_applies(input logic prev_dma, input logic next_dma,
                                           input logic any_mode);
    return prev_dma && (any_mode || next_dma);
  endfunction

endpackage

// File: rtl/bus_idle_gap_hist.sv
module bus_idle_gap_hist #(
  parameter int unsigned SPW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grant_i,
  input  logic           end_i,
  input  logic           nxt_write,
  input  logic [SPW-1:0] nxt_space,
  input  logic           nxt_dma,
  output logic           in_access,
  output logic           have_prev,
  output logic           prev_write,
  output logic [SPW-1:0] prev_space,
  output logic           prev_dma,
  output logic           end_evt
);

  assign end_evt = in_access && end_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_access  <= 1'b0;
      have_prev  <= 1'b0;
      prev_write <= 1'b0;
      prev_space <= '0;
      prev_dma   <= 1'b0;
    end else begin
      if (grant_i) begin
        in_access  <= 1'b1;
        prev_write <= nxt_write;
        prev_space <= nxt_space;
        prev_dma   <= nxt_dma;
      end else if (end_evt) begin
        in_access <= 1'b0;
        have_prev <= 1'b1;
      end
    end
  end

  // A start may only be granted while no access runs
  assert_grant_when_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> !in_access);

  // The access that ended becomes the reference for the next gap
  assert_end_sets_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (have_prev && !in_access && $stable(prev_space)));

endmodule

// File: rtl/bus_idle_gap_sel.sv
module bus_idle_gap_sel
  import bus_idle_gap_pkg::*;
#(
  parameter int unsigned NSPACE = 4,
  parameter int unsigned FW     = 3,
  localparam int unsigned SPW   = $clog2(NSPACE),
  localparam int unsigned WIDE  = NSPACE * FW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prev_write,
  input  logic [SPW-1:0]  prev_space,
  input  logic            prev_dma,
  input  logic            nxt_write,
  input  logic [SPW-1:0]  nxt_space,
  input  logic            nxt_dma,
  input  logic [WIDE-1:0] cfg_gap_wr,
  input  logic [WIDE-1:0] cfg_gap_rw_diff,
  input  logic [WIDE-1:0] cfg_gap_rw_same,
  input  logic [WIDE-1:0] cfg_gap_rr_diff,
  input  logic [WIDE-1:0] cfg_gap_rr_same,
  input  logic [FW-1:0]   cfg_dma_gap,
  input  logic            cfg_dma_any,
  output logic [FW-1:0]   norm_need,
  output logic            dma_hit,
  output logic [FW-1:0]   need
);

  logic [FW-1:0] wr_a     [NSPACE];
  logic [FW-1:0] rwd_a    [NSPACE];
  logic [FW-1:0] rws_a    [NSPACE];
  logic [FW-1:0] rrd_a    [NSPACE];
  logic [FW-1:0] rrs_a    [NSPACE];

  for (genvar g = 0; g < NSPACE; g++) begin : g_unpack
    assign wr_a[g]  = cfg_gap_wr[g*FW +: FW];
    assign rwd_a[g] = cfg_gap_rw_diff[g*FW +: FW];
    assign rws_a[g] = cfg_gap_rw_same[g*FW +: FW];
    assign rrd_a[g] = cfg_gap_rr_diff[g*FW +: FW];
    assign rrs_a[g] = cfg_gap_rr_same[g*FW +: FW];
  end

  gap_cat_e cat;
  logic     same_space;

  assign same_space = (prev_space == nxt_space);
  assign cat        = pick_cat(prev_write, nxt_write, same_space);

  always_comb begin
    unique case (cat)
      CAT_AFTER_WR: norm_need = wr_a[prev_space];
      CAT_RW_DIFF:  norm_need = rwd_a[prev_space];
      CAT_RW_SAME:  norm_need = rws_a[prev_space];
      CAT_RR_DIFF:  norm_need = rrd_a[prev_space];
      CAT_RR_SAME:  norm_need = rrs_a[prev_space];
      default:      norm_need = '0;
    endcase
  end

  assign dma_hit = dma_gap_applies(prev_dma, nxt_dma, cfg_dma_any);
  assign need    = dma_hit ? FW'(larger(int'(norm_need), int'(cfg_dma_gap))) : norm_need;

  // Without a DMA match the normal category alone decides
  assert_dma_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_hit |-> (need == norm_need));

  // A DMA match never shortens the gap below either source
  assert_dma_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_hit |-> ((need >= norm_need) && (need >= cfg_dma_gap)));

  // Any-mode: an externally driven DMA access always triggers the DMA rule
  assert_dma_any_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dma_any && prev_dma) |-> dma_hit);

endmodule

// File: rtl/bus_idle_gap_cnt.sv
module bus_idle_gap_cnt #(
  parameter int unsigned FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          run_i,
  output logic [FW-1:0] elapsed
);

  localparam logic [FW-1:0] CNT_TOP = '1;

  logic at_top;
  assign at_top = (elapsed == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
    end else if (clear_i) begin
      elapsed <= '0;
    end else if (run_i && !at_top) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  // Idle time is never lost while waiting: no wrap, only saturation
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (elapsed >= $past(elapsed)));

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (elapsed == '0));

endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import bus_idle_gap_pkg::*;
#(
  parameter int unsigned NSPACE = 4,
  parameter int unsigned FW     = 3,
  localparam int unsigned SPW   = $clog2(NSPACE),
  localparam int unsigned WIDE  = NSPACE * FW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [SPW-1:0]  req_space,
  input  logic            req_dma_ext,
  output logic            req_ready,
  input  logic            acc_end,
  input  logic [WIDE-1:0] cfg_gap_wr,
  input  logic [WIDE-1:0] cfg_gap_rw_diff,
  input  logic [WIDE-1:0] cfg_gap_rw_same,
  input  logic [WIDE-1:0] cfg_gap_rr_diff,
  input  logic [WIDE-1:0] cfg_gap_rr_same,
  input  logic [FW-1:0]   cfg_dma_gap,
  input  logic            cfg_dma_any,
  output logic            busy
);

  localparam logic [FW-1:0] CNT_TOP = '1;

  logic           grant;
  logic           in_access;
  logic           have_prev;
  logic           prev_write;
  logic [SPW-1:0] prev_space;
  logic           prev_dma;
  logic           end_evt;
  logic [FW-1:0]  norm_need;
  logic           dma_hit;
  logic [FW-1:0]  need;
  logic [FW-1:0]  elapsed;
  logic           gap_met;
  logic           held_off;

  bus_idle_gap_hist #(.SPW(SPW)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_i    (grant),
    .end_i      (acc_end),
    .nxt_write  (req_write),
    .nxt_space  (req_space),
    .nxt_dma    (req_dma_ext),
    .in_access  (in_access),
    .have_prev  (have_prev),
    .prev_write (prev_write),
    .prev_space (prev_space),
    .prev_dma   (prev_dma),
    .end_evt    (end_evt)
  );

  bus_idle_gap_sel #(.NSPACE(NSPACE), .FW(FW)) u_sel (
    .clk             (clk),
    .rst_n           (rst_n),
    .prev_write      (prev_write),
    .prev_space      (prev_space),
    .prev_dma        (prev_dma),
    .nxt_write       (req_write),
    .nxt_space       (req_space),
    .nxt_dma         (req_dma_ext),
    .cfg_gap_wr      (cfg_gap_wr),
    .cfg_gap_rw_diff (cfg_gap_rw_diff),
    .cfg_gap_rw_same (cfg_gap_rw_same),
    .cfg_gap_rr_diff (cfg_gap_rr_diff),
    .cfg_gap_rr_same (cfg_gap_rr_same),
    .cfg_dma_gap     (cfg_dma_gap),
    .cfg_dma_any     (cfg_dma_any),
    .norm_need       (norm_need),
    .dma_hit         (dma_hit),
    .need            (need)
  );

  bus_idle_gap_cnt #(.FW(FW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (end_evt),
    .run_i   (have_prev && !in_access),
    .elapsed (elapsed)
  );

  assign gap_met   = !have_prev || (elapsed >= need);
  assign req_ready = !in_access && gap_met;
  assign grant     = req_valid && req_ready;
  assign held_off  = req_valid && !req_ready;
  assign busy      = in_access || held_off;

  // Nothing to wait for before the first completed access
  assert_fresh_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!have_prev && !in_access) |-> req_ready);

  // A started access is reported as a bus cycle in progress
  assert_busy_after_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> busy);

  // A saturated idle count satisfies every field value
  assert_no_penalty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_access && have_prev && elapsed == CNT_TOP) |-> req_ready);

  // No start in the cycle that ends the running access
  assert_end_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |-> !req_ready);

endmodule

// File: tb/bus_idle_gap_bench.sv
`timescale 1ns/1ps
module bus_idle_gap_bench;

  localparam int NSP = 4;
  localparam int FWB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [1:0] req_space = '0;
  logic req_dma_ext = 1'b0;
  logic req_ready;
  logic acc_end = 1'b0;
  logic [NSP*FWB-1:0] cfg_gap_wr = '0, cfg_gap_rw_diff = '0, cfg_gap_rw_same = '0;
  logic [NSP*FWB-1:0] cfg_gap_rr_diff = '0, cfg_gap_rr_same = '0;
  logic [FWB-1:0] cfg_dma_gap = '0;
  logic cfg_dma_any = 1'b0;
  logic busy;

  always #2.5 clk = ~clk;

  bus_idle_gap u_bus_idle_gap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_space(req_space), .req_dma_ext(req_dma_ext), .req_ready(req_ready),
    .acc_end(acc_end), .cfg_gap_wr(cfg_gap_wr), .cfg_gap_rw_diff(cfg_gap_rw_diff),
    .cfg_gap_rw_same(cfg_gap_rw_same), .cfg_gap_rr_diff(cfg_gap_rr_diff),
    .cfg_gap_rr_same(cfg_gap_rr_same), .cfg_dma_gap(cfg_dma_gap),
    .cfg_dma_any(cfg_dma_any), .busy(busy)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  // field table: row 0 after-write, 1 rw diff, 2 rw same, 3 rr diff, 4 rr same
  int fld [5][NSP];
  int dma_val;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  task automatic load_cfg(input int k);
    for (int s = 0; s < NSP; s++) begin
      fld[0][s] = (3*s + 1 + k) % 8;
      fld[1][s] = (5*s + 2 + k) % 8;
      fld[2][s] = (s + 6 + 3*k) % 8;
      fld[3][s] = (7*s + 3 + k) % 8;
      fld[4][s] = (2*s + 5 + 2*k) % 8;
      cfg_gap_wr[s*FWB +: FWB]      = 3'(fld[0][s]);
      cfg_gap_rw_diff[s*FWB +: FWB] = 3'(fld[1][s]);
      cfg_gap_rw_same[s*FWB +: FWB] = 3'(fld[2][s]);
      cfg_gap_rr_diff[s*FWB +: FWB] = 3'(fld[3][s]);
      cfg_gap_rr_same[s*FWB +: FWB] = 3'(fld[4][s]);
    end
    dma_val = (k == 0) ? 5 : 2;
    cfg_dma_gap = 3'(dma_val);
  endtask

  function automatic int gap_of(int pw, int ps, int pd, int nw, int ns, int nd, int mode);
    int row, g;
    row = (pw != 0) ? 0 : ((nw != 0) ? 1 : 3) + ((ps == ns) ? 1 : 0);
    g = fld[row][ps];
    if (pd != 0 && (mode != 0 || nd != 0) && dma_val > g) g = dma_val;
    return g;
  endfunction

  // One access; returns the number of held-off cycles. Entered and left at posedge+1.
  task automatic do_access(input int w, input int sp, input int dm, output int waits);
    waits = 0;
    req_write = w[0]; req_space = 2'(sp); req_dma_ext = dm[0]; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      check(busy == 1'b1, "R11 busy while held off", int'(busy), 1);
      waits++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; acc_end = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b0, "R10 ready during access", int'(req_ready), 0);
    check(busy == 1'b1, "R11 busy during access", int'(busy), 1);
    @(posedge clk); #1;
    acc_end = 1'b0;
  endtask

  initial begin
    int w, exp, d, cnt;
    string tag;
    load_cfg(0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    @(posedge clk); #1;
    cnt = 0;
    for (int k = 0; k < 2; k++) begin
      load_cfg(k);
      for (int mode = 0; mode < 2; mode++) begin
        cfg_dma_any = mode[0];
        for (int code = 0; code < 16; code++) begin
          for (int ps = 0; ps < NSP; ps++) begin
            for (int ns = 0; ns < NSP; ns++) begin
              int pw, pd, nw, nd;
              pw = code & 1; pd = (code >> 1) & 1; nw = (code >> 2) & 1; nd = (code >> 3) & 1;
              d = (cnt % 4) * 3;
              cnt++;
              do_access(pw, ps, pd, w);
              repeat (d) @(posedge clk);
              #1;
              do_access(nw, ns, nd, w);
              exp = gap_of(pw, ps, pd, nw, ns, nd, mode) - d;
              if (exp < 0) exp = 0;
              if (pd != 0 && (mode != 0 || nd != 0)) tag = (mode != 0) ? "R7 dma any" : "R8 dma max";
              else if (pd != 0) tag = "R6 dma gated off";
              else if (d > 0) tag = "R9 idle credit";
              else if (ps != ns) tag = "R5 prev space field";
              else if (pw != 0) tag = "R2 after write";
              else if (nw != 0) tag = "R3 read then write";
              else tag = "R4 read then read";
              check(w == exp, tag, w, exp);
            end
          end
        end
      end
    end
    report();
  end

endmodule